// File: doc/BRIEF.md
# Dual-Bank Interrupt Mask Controller

This block collects two groups of level-sensitive interrupt request lines, a normal group and a fast group. It reduces each group to one interrupt output. Every group has its own bank of state: a registered copy of the request lines (the raw status), an enable mask, and a masked view that is the raw status ANDed with the mask. Software never writes the mask as a whole word. It ORs bits in through an enable-set register and removes them through an enable-clear register. Concurrent handlers can therefore each touch their own bits without a read-modify-write.

Software reaches the block through a single-cycle register port with a word address. The address has three bits. Bit 2 picks the bank: 0 is the normal bank and 1 is the fast bank. Bits 1:0 pick the register: 0 is masked status, 1 is raw status, 2 is enable-set and 3 is enable-clear. Read data is registered. It appears the cycle after the read strobe and holds until the next read. A write to either status register changes nothing and raises a one-cycle error pulse.

Top module: `irq_dual_mask_ctrl`

## Requirements
- R1: Raw status (register offset 1 of a bank) equals that bank's request lines as sampled at the previous rising clock edge. Dropping a request line clears its raw bit one cycle later.
- R2: Reading masked status (offset 0) returns the bank's raw status ANDed with its enable mask.
- R3: A write to enable-set (offset 2) ORs the write data into the bank's enable mask. Bits written as 0 keep their value.
- R4: A write to enable-clear (offset 3) clears every enable bit where the write data holds a 1. All other bits keep their value.
- R5: Each bank's interrupt output is high exactly when (raw status AND enable mask) is nonzero. It follows a mask write, or a change in the request lines, one clock edge after the stimulus.
- R6: The two banks are independent. Writes addressed to one bank (address bit 2) leave the other bank's mask and output unchanged. The fast output is driven only by the fast bank.
- R7: A write to either status register (offset 0 or 1) leaves both masks unchanged and drives wr_err_o high for exactly one cycle, the cycle after the write. Writes to offsets 2 and 3 never raise it.
- R8: Reading enable-set or enable-clear returns the bank's current enable mask.
- R9: After reset, both enable masks are zero, both interrupt outputs are low, wr_err_o is low and rdata_o is zero.
- R10: rdata_o is loaded at the clock edge that samples rd_en_i high. It holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| nrm_req_i | input | N_LINES | Level request lines of the normal bank |
| fst_req_i | input | N_LINES | Level request lines of the fast bank |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address: bit 2 bank, bits 1:0 register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| nrm_irq_o | output | 1 | Normal interrupt output |
| fst_irq_o | output | 1 | Fast interrupt output |
| wr_err_o | output | 1 | One-cycle pulse after a write to a status register |

## Verification
Every result in this block is due exactly one rising edge after its stimulus:
- raw status after a request change;
- the enable mask and both outputs after a set or clear write;
- the error pulse after a rejected write;
- read data after a read strobe.

The bench drives all inputs on falling edges. It samples on the falling edge that follows the single rising edge after each stimulus, so each value is observed in its first valid cycle. The error pulse is sampled a second time one cycle later, to show it has dropped.

The main sweep walks a single request bit through all 32 positions of each bank. The expected masks and masked words are computed from the set/clear arithmetic. Arithmetic patterns then mix many bits, including cases where the mask and the requests do not overlap at all.

// File: rtl/irq_mask_pkg.sv
// Package: shared register-select encoding and bank indices for the
// dual-bank interrupt mask controller.
// Assumes: word addresses, bank picked by address bit 2, register by bits 1:0.
package irq_mask_pkg;

    // Number of banks (normal and fast) and their indices.
    localparam int N_BANKS    = 2;
    localparam int BANK_NRM   = 0;
    localparam int BANK_FST   = 1;

    // Address layout inside the word address.
    localparam int SEL_W      = 2;
    localparam int BANK_LSB   = SEL_W;
    localparam int MAP_BITS   = SEL_W + 1;

    // Register selected by the low address bits.
    typedef enum logic [SEL_W-1:0] {
        REG_MASKED = 2'd0,
        REG_RAW    = 2'd1,
        REG_EN_SET = 2'd2,
        REG_EN_CLR = 2'd3
    } reg_sel_e;

    // True when the selector names a read-only status register.
    function automatic logic is_status(input reg_sel_e sel);
        return (sel == REG_MASKED) || (sel == REG_RAW);
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
// Module: irq_src_latch
// Registers a group of level request lines into the raw status word,
// one flop per line. Line i lands in bit i.
// Assumes: request lines are already synchronous to clk.
module irq_src_latch #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    output logic [N_LINES-1:0] raw_o
);

    logic [N_LINES-1:0] raw_q;

    // One flop per request line; built by generate so each line is its own cell.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        // Capture request level g on every edge; clear in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) raw_q[g] <= 1'b0;
            else        raw_q[g] <= req_i[g];
        end
    end

    assign raw_o = raw_q;

    // Raw status reproduces the lines seen one edge earlier.
    AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (raw_q == $past(req_i))); // R1

endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// One interrupt bank: latches its request lines, holds an enable mask
// changed only by set/clear strobes, and forms the masked view and the
// bank's interrupt output.
// Assumes: set and clear strobes are never high in the same cycle.
module irq_mask_bank #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               set_stb_i,
    input  logic               clr_stb_i,
    input  logic [N_LINES-1:0] wmask_i,
    output logic [N_LINES-1:0] raw_o,
    output logic [N_LINES-1:0] en_o,
    output logic [N_LINES-1:0] masked_o,
    output logic               irq_o
);

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] en_q;
    logic [N_LINES-1:0] en_d;

    irq_src_latch #(
        .N_LINES (N_LINES)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .raw_o (raw)
    );

    // Next mask: OR in on set, knock out on clear, hold otherwise.
    always_comb begin
        en_d = en_q;
        if (set_stb_i)      en_d = en_q | wmask_i;
        else if (clr_stb_i) en_d = en_q & ~wmask_i;
    end

    // Mask register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign raw_o    = raw;
    assign en_o     = en_q;
    assign masked_o = raw & en_q;
    assign irq_o    = |masked_o;

    // A set write ORs the data into the previous mask.
    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> (en_q == ($past(en_q) | $past(wmask_i)))); // R3

    // A clear write removes exactly the written ones.
    AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_i |=> (en_q == ($past(en_q) & ~$past(wmask_i)))); // R4

    // Without a strobe the mask does not move.
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb_i && !clr_stb_i) |=> $stable(en_q)); // R6

    // The output may only rise after a set write or a request change.
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(irq_o)) |->
            ($past(set_stb_i) || ($past(req_i) != $past(raw)))); // R5

    // The output may only fall after a clear write or a request change.
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(irq_o)) |->
            ($past(clr_stb_i) || ($past(req_i) != $past(raw)))); // R5

    // The cycle after reset the mask is empty and the output quiet.
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((en_q == '0) && !irq_o)); // R9

endmodule

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Register port of the controller: decodes the word address into
// per-bank set/clear strobes, flags rejected writes to status registers,
// and registers read data from the selected bank view.
// Assumes: ADDR_W >= 3; address bits above bit 2 must be zero for a hit.
module irq_reg_port
    import irq_mask_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en_i,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [N_BANKS-1:0][N_LINES-1:0]   raw_i,
    input  logic [N_BANKS-1:0][N_LINES-1:0]   masked_i,
    input  logic [N_BANKS-1:0][N_LINES-1:0]   en_i,
    output logic [N_BANKS-1:0]                set_stb_o,
    output logic [N_BANKS-1:0]                clr_stb_o,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic                              wr_err_o
);

    reg_sel_e           sel;
    logic               bank;
    logic               hit;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q;

    // Split the address into bank, register and a range check.
    always_comb begin
        sel  = reg_sel_e'(addr_i[SEL_W-1:0]);
        bank = addr_i[BANK_LSB];
        hit  = ((addr_i >> MAP_BITS) == '0);
    end

    // Per-bank write strobes; only the addressed bank sees a strobe.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_stb
        always_comb begin
            set_stb_o[b] = wr_en_i && hit && (int'(bank) == b) && (sel == REG_EN_SET);
            clr_stb_o[b] = wr_en_i && hit && (int'(bank) == b) && (sel == REG_EN_CLR);
        end
    end

    // Pick the view named by the selector, zero-extended to the data width.
    always_comb begin
        rd_mux = '0;
        if (hit) begin
            unique case (sel)
                REG_MASKED: rd_mux = DATA_W'(masked_i[bank]);
                REG_RAW:    rd_mux = DATA_W'(raw_i[bank]);
                REG_EN_SET,
                REG_EN_CLR: rd_mux = DATA_W'(en_i[bank]);
                default:    rd_mux = '0;
            endcase
        end
    end

    // Load read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    // One-cycle error pulse for a write aimed at a status register.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_en_i && hit && is_status(sel);
    end

    assign rdata_o  = rdata_q;
    assign wr_err_o = err_q;

    // An error pulse must trace back to a write of a status register.
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_q) |->
            ($past(wr_en_i) && ($past(addr_i[SEL_W-1:0]) <= 2'd1))); // R7

    // No more than one strobe of any kind per cycle.
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_stb_o, clr_stb_o})); // R6

    // Read data only moves on a read strobe.
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en_i)) |-> $stable(rdata_q)); // R10

endmodule

// File: rtl/irq_dual_mask_ctrl.sv
// Module: irq_dual_mask_ctrl (top)
// Two interrupt banks, normal and fast, behind one word-addressed
// register port. Each bank reduces its request lines to one output
// through a set/clear enable mask.
// Assumes: N_LINES <= DATA_W, ADDR_W >= 3, synchronous request lines.
module irq_dual_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] nrm_req_i,
    input  logic [N_LINES-1:0] fst_req_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               nrm_irq_o,
    output logic               fst_irq_o,
    output logic               wr_err_o
);

    logic [N_BANKS-1:0][N_LINES-1:0] req_all;
    logic [N_BANKS-1:0][N_LINES-1:0] raw_all;
    logic [N_BANKS-1:0][N_LINES-1:0] en_all;
    logic [N_BANKS-1:0][N_LINES-1:0] masked_all;
    logic [N_BANKS-1:0]              set_stb;
    logic [N_BANKS-1:0]              clr_stb;
    logic [N_BANKS-1:0]              irq_all;

    // Route each request group to its bank index.
    always_comb begin
        req_all[BANK_NRM] = nrm_req_i;
        req_all[BANK_FST] = fst_req_i;
    end

    irq_reg_port #(
        .N_LINES (N_LINES),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .raw_i     (raw_all),
        .masked_i  (masked_all),
        .en_i      (en_all),
        .set_stb_o (set_stb),
        .clr_stb_o (clr_stb),
        .rdata_o   (rdata_o),
        .wr_err_o  (wr_err_o)
    );

    // One bank instance per interrupt output.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        irq_mask_bank #(
            .N_LINES (N_LINES)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_all[b]),
            .set_stb_i (set_stb[b]),
            .clr_stb_i (clr_stb[b]),
            .wmask_i   (wdata_i[N_LINES-1:0]),
            .raw_o     (raw_all[b]),
            .en_o      (en_all[b]),
            .masked_o  (masked_all[b]),
            .irq_o     (irq_all[b])
        );
    end

    assign nrm_irq_o = irq_all[BANK_NRM];
    assign fst_irq_o = irq_all[BANK_FST];

    // A status write leaves both masks where they were.
    AST_STATUS_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i[SEL_W-1:0] <= 2'd1)) |=> $stable(en_all)); // R7

    // Out of reset nothing is flagged and read data is clear.
    AST_RESET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!wr_err_o && (rdata_o == '0) && !nrm_irq_o && !fst_irq_o)); // R9

endmodule

// File: tb/tb_irq_dual_mask_ctrl.sv
module tb_irq_dual_mask_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] nrm_req = '0;
    logic [31:0] fst_req = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nrm_irq;
    logic        fst_irq;
    logic        wr_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_en [2];
    logic [31:0] exp_req [2];

    always #5 clk = ~clk;

    irq_dual_mask_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrm_req_i (nrm_req),
        .fst_req_i (fst_req),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .nrm_irq_o (nrm_irq),
        .fst_irq_o (fst_irq),
        .wr_err_o  (wr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic irq_of(input int b);
        return (b == 0) ? nrm_irq : fst_irq;
    endfunction

    function automatic logic [2:0] adr(input int b, input int sel);
        return 3'((b << 2) | sel);
    endfunction

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_req(input int b, input logic [31:0] v);
        @(negedge clk);
        if (b == 0) nrm_req = v; else fst_req = v;
        exp_req[b] = v;
        @(negedge clk);
    endtask

    task automatic set_en(input int b, input logic [31:0] v);
        do_write(adr(b, 2), v);
        exp_en[b] = exp_en[b] | v;
    endtask

    task automatic clr_en(input int b, input logic [31:0] v);
        do_write(adr(b, 3), v);
        exp_en[b] = exp_en[b] & ~v;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] bitv;
        logic [31:0] en_pat;
        logic [31:0] rq_pat;
        logic [31:0] keep0;
        logic [31:0] keep1;
        exp_en[0] = '0; exp_en[1] = '0;
        exp_req[0] = '0; exp_req[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of outputs and every register.
        chk("R9 nrm_irq", 32'(nrm_irq), 0);
        chk("R9 fst_irq", 32'(fst_irq), 0);
        chk("R9 wr_err", 32'(wr_err), 0);
        chk("R9 rdata", rdata, 0);
        for (int a = 0; a < 8; a++) begin
            do_read(3'(a), rd);
            chk("R9 reg", rd, 0);
        end

        // Walk one request bit through every position of each bank.
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 32; i++) begin
                bitv = 32'h1 << i;
                drive_req(b, bitv);
                chk("R5 masked-off low", 32'(irq_of(b)), 0);
                do_read(adr(b, 1), rd);
                chk("R1 raw", rd, bitv);
                set_en(b, bitv);
                chk("R5 enabled high", 32'(irq_of(b)), 1);
                chk("R6 other bank low", 32'(irq_of(1 - b)), 0);
                do_read(adr(b, 0), rd);
                chk("R2 masked", rd, bitv);
                do_read(adr(b, 2), rd);
                chk("R8 set reg", rd, exp_en[b]);
                do_read(adr(b, 3), rd);
                chk("R8 clr reg", rd, exp_en[b]);
                do_read(adr(1 - b, 2), rd);
                chk("R6 other mask", rd, exp_en[1 - b]);
                clr_en(b, bitv);
                chk("R4 cleared low", 32'(irq_of(b)), 0);
                do_read(adr(b, 0), rd);
                chk("R4 masked zero", rd, 0);
            end
            drive_req(b, 32'h0);
            do_read(adr(b, 1), rd);
            chk("R1 raw cleared", rd, 0);
        end

        // R3/R4: accumulate and partially clear.
        set_en(0, 32'hF0F0_0000);
        set_en(0, 32'h0000_00FF);
        do_read(adr(0, 2), rd);
        chk("R3 or accumulate", rd, 32'hF0F0_00FF);
        clr_en(0, 32'h3000_000F);
        do_read(adr(0, 3), rd);
        chk("R4 partial clear", rd, 32'hC0F0_00F0);
        clr_en(0, 32'hFFFF_FFFF);

        // Arithmetic patterns over both banks.
        for (int k = 0; k < 16; k++) begin
            int b;
            b = k % 2;
            rq_pat = 32'hC3A5_0F96 ^ (32'h0101_0101 * 32'(k));
            en_pat = (k % 4 == 3) ? ~rq_pat : (32'h9E37_79B9 * 32'(k + 1));
            clr_en(b, 32'hFFFF_FFFF);
            set_en(b, en_pat);
            drive_req(b, rq_pat);
            do_read(adr(b, 0), rd);
            chk("R2 pattern masked", rd, rq_pat & en_pat);
            chk("R5 pattern irq", 32'(irq_of(b)), 32'(|(rq_pat & en_pat)));
            do_read(adr(b, 1), rd);
            chk("R1 pattern raw", rd, rq_pat);
        end

        // R5: request drop lowers the output one edge later.
        clr_en(1, 32'hFFFF_FFFF);
        set_en(1, 32'h0000_0400);
        drive_req(1, 32'h0000_0400);
        chk("R5 rise on request", 32'(fst_irq), 1);
        drive_req(1, 32'h0);
        chk("R5 fall on drop", 32'(fst_irq), 0);

        // R7: status writes rejected with a one-cycle pulse.
        set_en(0, 32'h1234_5678);
        for (int s = 0; s < 4; s++) begin
            logic [2:0] a;
            a = adr(s / 2, s % 2);
            keep0 = exp_en[0]; keep1 = exp_en[1];
            do_write(a, 32'hFFFF_FFFF);
            chk("R7 err pulse", 32'(wr_err), 1);
            @(negedge clk);
            chk("R7 err drops", 32'(wr_err), 0);
            do_read(adr(0, 2), rd);
            chk("R7 nrm mask kept", rd, keep0);
            do_read(adr(1, 2), rd);
            chk("R7 fst mask kept", rd, keep1);
        end
        set_en(1, 32'h0000_0001);
        chk("R7 no err on set", 32'(wr_err), 0);
        clr_en(1, 32'h0000_0001);
        chk("R7 no err on clr", 32'(wr_err), 0);

        // R10: read data holds without a strobe.
        do_read(adr(0, 3), rd);
        chk("R10 read value", rd, exp_en[0]);
        clr_en(0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 rdata held", rdata, rd);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule